// File: doc/BRIEF.md
# Capacitor Update Packet Sequencer

This block is the central manager of a deformable-mirror drive chain. It pulls two-byte capacitor entries out of a byte FIFO and turns each one into a 6-bit capacitor number, an 8-bit voltage code and two padding bits. For every valid entry it writes the voltage to a DAC port and then asks a high-voltage sample-and-hold controller to capture the DAC output into the correct hold channel. A full mirror update has 59 entries, one for each capacitor, and each voltage has 256 levels. The whole update has to fit within a 20 ms frame period. The intended budget is about 2 ms.

The hold stage has two banks. Each bank is addressed by a 5-bit channel select. Capacitors 0..31 go to bank A on channel = index. Capacitors 32..58 go to bank B on channel = index - 32. The sequencer brings the high-voltage stage up, keeps it sampling and takes it down again. Each of these steps is a request held until the matching finish signal arrives. Three key inputs control the block: start, shutdown and reset. Each key is a single-cycle synchronous pulse that has been debounced upstream.

Top module: `cap_frame_sequencer`

## Requirements
- R1: After rst, every request output is low, as are fifo_rdreq, dac_wr, both hold enables and frame_done. err_count is 0 and fmt_err is 0.
- R2: While powered off, the block reads nothing from the FIFO. A key_start pulse while off raises pu_req on the next cycle. pu_req stays high until pu_done is seen. No FIFO read happens before that finish.
- R3: An entry is two bytes read in order. In the first byte, bits [7:2] hold the capacitor index and bits [1:0] hold the padding. The second byte is the voltage. For indices 0..58, one dac_wr pulse follows, carrying the voltage on dac_data. dac_bank is 0 for index 0..31 and 1 for index 32..58. dac_chan is index for bank A and index-32 for bank B.
- R4: After each DAC write the block raises smp_req. While smp_req is high, exactly the enable of the addressed bank is high, with that bank's select equal to the channel. The next entry is not fetched until smp_done.
- R5: An index of 59..63 produces no DAC write and no sampling. It increments err_count, which saturates at its maximum.
- R6: Padding other than 00 sets fmt_err, which stays set until a reset. The entry is still applied as in R3 and R4.
- R7: fifo_rdreq is asserted only while fifo_empty is low. Gaps in FIFO data only stall the block.
- R8: frame_done pulses for one cycle after every 59th completed entry since power-up. Dropped entries count toward the 59.
- R9: key_start while powered is ignored. key_shutdown is acted on only at an entry boundary. It raises pd_req, which stays high until pd_done, and after that no further entries are read. At most one of pu_req, smp_req and pd_req is high at a time.
- R10: A key_reset pulse has the same effect as rst. On the next cycle all requests are low, err_count is 0, fmt_err is 0 and the block is powered off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_start | input | 1 | Start key pulse |
| key_shutdown | input | 1 | Shutdown key pulse |
| key_reset | input | 1 | Reset key pulse |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_q | input | 8 | FIFO read data, valid the cycle after a read |
| fifo_rdreq | output | 1 | FIFO read request |
| dac_wr | output | 1 | DAC write strobe |
| dac_data | output | 8 | DAC voltage code |
| dac_bank | output | 1 | Target bank: 0 = A, 1 = B |
| dac_chan | output | 5 | Channel within the bank |
| pu_req | output | 1 | High-voltage power-up request |
| pu_done | input | 1 | Power-up finished |
| smp_req | output | 1 | Sample request |
| smp_done | input | 1 | Sample finished |
| pd_req | output | 1 | Power-down request |
| pd_done | input | 1 | Power-down finished |
| hold_en_a | output | 1 | Bank A channel enable |
| hold_sel_a | output | 5 | Bank A channel select |
| hold_en_b | output | 1 | Bank B channel enable |
| hold_sel_b | output | 5 | Bank B channel select |
| frame_done | output | 1 | One-cycle pulse at each completed frame |
| err_count | output | 8 | Saturating count of dropped entries |
| fmt_err | output | 1 | Sticky padding error flag |

## Verification
The hardest situation to reach is a shutdown key that arrives while the sequencer is halfway through an entry. The bench creates it by pushing only the first byte of an entry, so the block stalls waiting for the voltage byte. It then presses shutdown and confirms that no power-down request appears yet. Finally it supplies the second byte and checks that the entry is written before the power-down handshake starts. The frame boundary is also exercised deliberately: the frame mixes dropped indices, a padding error and both bank edges (31, 32, 58), and the bench checks that frame_done has not fired one entry before the 59th.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int CAP_COUNT = 59;
    localparam int IDX_W     = 6;
    localparam int VOLT_W    = 8;
    localparam int CHAN_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int PAD_W     = BYTE_W - IDX_W;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PWRUP,
        ST_READY,
        ST_WAIT_HI,
        ST_FETCH_LO,
        ST_WAIT_LO,
        ST_DECODE,
        ST_DAC,
        ST_SAMPLE,
        ST_PWRDN
    } seq_state_t;

    typedef struct packed {
        logic              ok;
        logic              bank;
        logic [CHAN_W-1:0] chan;
        logic [VOLT_W-1:0] volt;
        logic              pad_bad;
    } entry_t;

    // Handshake slot numbering
    localparam int HS_PU  = 0;
    localparam int HS_SMP = 1;
    localparam int HS_PD  = 2;
    localparam int HS_NUM = 3;

endpackage

// File: rtl/cfs_entry_unpack.sv
module cfs_entry_unpack
    import cfs_pkg::*;
#(
    parameter int NUM_CAPS = CAP_COUNT
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output entry_t            ent
);
    logic [IDX_W-1:0] idx;
    logic [PAD_W-1:0] pad;

    always_comb begin
        idx         = hi_byte[BYTE_W-1:PAD_W];
        pad         = hi_byte[PAD_W-1:0];
        ent.ok      = (int'(idx) < NUM_CAPS);
        ent.bank    = idx[CHAN_W];
        ent.chan    = idx[CHAN_W-1:0];
        ent.volt    = lo_byte;
        ent.pad_bad = (pad != '0);
    end
endmodule

// File: rtl/cfs_hs.sv
module cfs_hs (
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic done,
    output logic req,
    output logic finish
);
    assign finish = req & done;

    always_ff @(posedge clk) begin
        if (clr)
            req <= 1'b0;
        else if (finish)
            req <= 1'b0;
        else if (start)
            req <= 1'b1;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (clr)
        req && !done |=> req);  // R2

    AST_FINISH_DROPS: assert property (@(posedge clk) disable iff (clr)
        req && done |=> !req);  // R9
endmodule

// File: rtl/cfs_err_track.sv
module cfs_err_track #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             bad_idx,
    input  logic             bad_pad,
    output logic [ERR_W-1:0] err_cnt,
    output logic             fmt_err
);
    always_ff @(posedge clk) begin
        if (clr) begin
            err_cnt <= '0;
            fmt_err <= 1'b0;
        end else begin
            if (bad_idx && (err_cnt != {ERR_W{1'b1}}))
                err_cnt <= err_cnt + 1'b1;
            if (bad_pad)
                fmt_err <= 1'b1;
        end
    end

    AST_ERR_MONO: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> err_cnt >= $past(err_cnt));  // R5

    AST_FMT_STICKY: assert property (@(posedge clk) disable iff (clr)
        fmt_err |=> fmt_err);  // R6
endmodule

// File: rtl/cap_frame_sequencer.sv
module cap_frame_sequencer
    import cfs_pkg::*;
#(
    parameter int NUM_CAPS = CAP_COUNT,
    parameter int ERR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_start,
    input  logic              key_shutdown,
    input  logic              key_reset,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_q,
    output logic              fifo_rdreq,
    output logic              dac_wr,
    output logic [VOLT_W-1:0] dac_data,
    output logic              dac_bank,
    output logic [CHAN_W-1:0] dac_chan,
    output logic              pu_req,
    input  logic              pu_done,
    output logic              smp_req,
    input  logic              smp_done,
    output logic              pd_req,
    input  logic              pd_done,
    output logic              hold_en_a,
    output logic [CHAN_W-1:0] hold_sel_a,
    output logic              hold_en_b,
    output logic [CHAN_W-1:0] hold_sel_b,
    output logic              frame_done,
    output logic [ERR_W-1:0]  err_count,
    output logic              fmt_err
);
    localparam int CNT_W      = $clog2(NUM_CAPS);
    localparam int BANK_B_TOP = NUM_CAPS - (1 << CHAN_W);

    logic              soft_clr;
    seq_state_t        st, st_n;
    logic [BYTE_W-1:0] hi_q, lo_q;
    entry_t            ent;
    logic              sd_pend;
    logic              entry_done;
    logic [CNT_W-1:0]  ent_cnt;
    logic [HS_NUM-1:0] hs_start, hs_done, hs_req, hs_fin;

    assign soft_clr = rst | key_reset;

    // Entry decode
    cfs_entry_unpack #(.NUM_CAPS(NUM_CAPS)) u_unpack (
        .hi_byte (hi_q),
        .lo_byte (lo_q),
        .ent     (ent)
    );

    // Handshake ports toward the high-voltage controller
    assign hs_done[HS_PU]  = pu_done;
    assign hs_done[HS_SMP] = smp_done;
    assign hs_done[HS_PD]  = pd_done;

    generate
        for (genvar g = 0; g < HS_NUM; g++) begin : g_hs
            cfs_hs u_hs (
                .clk    (clk),
                .clr    (soft_clr),
                .start  (hs_start[g]),
                .done   (hs_done[g]),
                .req    (hs_req[g]),
                .finish (hs_fin[g])
            );
        end
    endgenerate

    assign pu_req  = hs_req[HS_PU];
    assign smp_req = hs_req[HS_SMP];
    assign pd_req  = hs_req[HS_PD];

    // Next-state logic
    always_comb begin
        st_n = st;
        case (st)
            ST_OFF:      if (key_start) st_n = ST_PWRUP;
            ST_PWRUP:    if (hs_fin[HS_PU]) st_n = ST_READY;
            ST_READY: begin
                if (sd_pend || key_shutdown) st_n = ST_PWRDN;
                else if (!fifo_empty)        st_n = ST_WAIT_HI;
            end
            ST_WAIT_HI:  st_n = ST_FETCH_LO;
            ST_FETCH_LO: if (!fifo_empty) st_n = ST_WAIT_LO;
            ST_WAIT_LO:  st_n = ST_DECODE;
            ST_DECODE:   st_n = ent.ok ? ST_DAC : ST_READY;
            ST_DAC:      st_n = ST_SAMPLE;
            ST_SAMPLE:   if (hs_fin[HS_SMP]) st_n = ST_READY;
            ST_PWRDN:    if (hs_fin[HS_PD]) st_n = ST_OFF;
            default:     st_n = ST_OFF;
        endcase
    end

    always_comb begin
        hs_start         = '0;
        hs_start[HS_PU]  = (st == ST_OFF) && key_start;
        hs_start[HS_SMP] = (st == ST_DAC);
        hs_start[HS_PD]  = (st == ST_READY) && (st_n == ST_PWRDN);
    end

    assign fifo_rdreq = ((st == ST_READY) && (st_n == ST_WAIT_HI)) ||
                        ((st == ST_FETCH_LO) && !fifo_empty);

    assign entry_done = ((st == ST_DECODE) && !ent.ok) ||
                        ((st == ST_SAMPLE) && hs_fin[HS_SMP]);

    always_ff @(posedge clk) begin
        if (soft_clr) begin
            st      <= ST_OFF;
            hi_q    <= '0;
            lo_q    <= '0;
            sd_pend <= 1'b0;
        end else begin
            st <= st_n;
            if (st == ST_WAIT_HI) hi_q <= fifo_q;
            if (st == ST_WAIT_LO) lo_q <= fifo_q;
            if (hs_start[HS_PD])
                sd_pend <= 1'b0;
            else if (key_shutdown && (st != ST_OFF) && (st != ST_PWRDN))
                sd_pend <= 1'b1;
        end
    end

    // Frame counter
    always_ff @(posedge clk) begin
        if (soft_clr) begin
            ent_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (hs_start[HS_PD]) begin
                ent_cnt <= '0;
            end else if (entry_done) begin
                if (ent_cnt == CNT_W'(NUM_CAPS - 1)) begin
                    ent_cnt    <= '0;
                    frame_done <= 1'b1;
                end else begin
                    ent_cnt <= ent_cnt + 1'b1;
                end
            end
        end
    end

    cfs_err_track #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .clr     (soft_clr),
        .bad_idx ((st == ST_DECODE) && !ent.ok),
        .bad_pad ((st == ST_DECODE) && ent.pad_bad),
        .err_cnt (err_count),
        .fmt_err (fmt_err)
    );

    // DAC and hold outputs
    assign dac_wr     = (st == ST_DAC);
    assign dac_data   = ent.volt;
    assign dac_bank   = ent.bank;
    assign dac_chan   = ent.chan;
    assign hold_en_a  = hs_req[HS_SMP] && !ent.bank;
    assign hold_en_b  = hs_req[HS_SMP] &&  ent.bank;
    assign hold_sel_a = ent.bank ? '0 : ent.chan;
    assign hold_sel_b = ent.bank ? ent.chan : '0;

    AST_RD_SPACED: assert property (@(posedge clk) disable iff (rst)
        fifo_rdreq |=> !fifo_rdreq);  // R3

    AST_NO_RD_HV_STEP: assert property (@(posedge clk) disable iff (rst)
        (pu_req || pd_req) |-> !fifo_rdreq);  // R2

    AST_HS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pu_req, smp_req, pd_req}));  // R9

    AST_DAC_THEN_SAMPLE: assert property (@(posedge clk) disable iff (soft_clr)
        dac_wr |=> smp_req);  // R4

    AST_HOLD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hold_en_a, hold_en_b}));  // R4

    AST_BANK_B_RANGE: assert property (@(posedge clk) disable iff (rst)
        dac_wr && dac_bank |-> int'(dac_chan) < BANK_B_TOP);  // R3

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);  // R8

    AST_KEY_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        key_reset |=> !pu_req && !smp_req && !pd_req && (err_count == '0) && !fmt_err);  // R10
endmodule

// File: tb/test_cap_frame_sequencer.sv
module test_cap_frame_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_start = 1'b0, key_shutdown = 1'b0, key_reset = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_q;
    logic       fifo_rdreq;
    logic       dac_wr, dac_bank;
    logic [7:0] dac_data;
    logic [4:0] dac_chan, hold_sel_a, hold_sel_b;
    logic       pu_req, smp_req, pd_req;
    logic       pu_done = 1'b0, smp_done = 1'b0, pd_done = 1'b0;
    logic       hold_en_a, hold_en_b, frame_done, fmt_err;
    logic [7:0] err_count;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    cap_frame_sequencer i_cap_frame_sequencer (.*);

    // FIFO model: data appears the cycle after a read
    logic [7:0] fmem [256];
    int wp = 0, rp = 0;
    assign fifo_empty = (wp == rp);
    always @(posedge clk) if (fifo_rdreq) begin fifo_q <= fmem[rp % 256]; rp <= rp + 1; end

    // High-voltage controller model: finish 3 cycles into a request
    int pu_c = 0, smp_c = 0, pd_c = 0;
    always @(negedge clk) begin
        if (!pu_req)  begin pu_c = 0;  pu_done = 1'b0;  end else begin pu_c++;  pu_done = (pu_c == 3);  end
        if (!smp_req) begin smp_c = 0; smp_done = 1'b0; end else begin smp_c++; smp_done = (smp_c == 3); end
        if (!pd_req)  begin pd_c = 0;  pd_done = 1'b0;  end else begin pd_c++;  pd_done = (pd_c == 3);  end
    end

    // Monitor
    int wr_n = 0, smp_n = 0, fd_n = 0, pu_rise = 0, pd_rise = 0, rd_bad = 0, rd_hv = 0;
    int wr_v [128], wr_b [128], wr_c [128], sm_b [128], sm_c [128];
    logic pu_q = 1'b0, pd_q = 1'b0, en_q = 1'b0;
    always @(negedge clk) begin
        if (fifo_rdreq && fifo_empty) rd_bad++;
        if (fifo_rdreq && (pu_req || pd_req)) rd_hv++;
        if (dac_wr && wr_n < 128) begin
            wr_v[wr_n] = dac_data; wr_b[wr_n] = dac_bank; wr_c[wr_n] = dac_chan; wr_n++;
        end
        if ((hold_en_a || hold_en_b) && !en_q && smp_n < 128) begin
            sm_b[smp_n] = hold_en_b; sm_c[smp_n] = hold_en_b ? hold_sel_b : hold_sel_a;
            if (hold_en_a && hold_en_b) sm_b[smp_n] = 9;
            smp_n++;
        end
        en_q = hold_en_a || hold_en_b;
        if (frame_done) fd_n++;
        if (pu_req && !pu_q) pu_rise++;
        if (pd_req && !pd_q) pd_rise++;
        pu_q = pu_req; pd_q = pd_req;
    end

    // Expected results, computed from the requirements
    int exp_v [128], exp_b [128], exp_c [128];
    int exp_n = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        fmem[wp % 256] = b;
        wp = wp + 1;
    endtask

    task automatic push_entry(input int idx, input int pad, input int volt);
        push_byte(8'((idx << 2) | pad));
        repeat (2) @(negedge clk);
        push_byte(8'(volt));
        if (idx < 59) begin
            exp_v[exp_n] = volt;
            exp_b[exp_n] = (idx >= 32) ? 1 : 0;
            exp_c[exp_n] = (idx >= 32) ? idx - 32 : idx;
            exp_n++;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) key_start = 1'b1;
        if (which == 1) key_shutdown = 1'b1;
        if (which == 2) key_reset = 1'b1;
        @(negedge clk);
        key_start = 1'b0; key_shutdown = 1'b0; key_reset = 1'b0;
    endtask

    task automatic compare_logs(input int from);
        check("R3 write count", wr_n, exp_n);
        check("R4 sample count", smp_n, exp_n);
        for (int k = from; k < exp_n; k++) begin
            check("R3 dac_data", wr_v[k], exp_v[k]);
            check("R3 dac_bank", wr_b[k], exp_b[k]);
            check("R3 dac_chan", wr_c[k], exp_c[k]);
            check("R4 hold bank", sm_b[k], exp_b[k]);
            check("R4 hold sel", sm_c[k], exp_c[k]);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pu_req", pu_req, 0);
        check("R1 smp_req", smp_req, 0);
        check("R1 pd_req", pd_req, 0);
        check("R1 rdreq", fifo_rdreq, 0);
        check("R1 dac_wr", dac_wr, 0);
        check("R1 hold enables", hold_en_a | hold_en_b, 0);
        check("R1 frame_done", frame_done, 0);
        check("R1 err_count", err_count, 0);
        check("R1 fmt_err", fmt_err, 0);
    endtask

    task automatic t_power_up;
        push_entry(3, 0, 8'hA5);
        repeat (20) @(negedge clk);
        check("R2 no read while off", rp, 0);
        @(negedge clk) key_start = 1'b1;
        @(negedge clk) key_start = 1'b0;
        check("R2 pu_req raised", pu_req, 1);
        check("R2 no read before finish", rp, 0);
        repeat (40) @(negedge clk);
        check("R2 pu_req dropped", pu_req, 0);
        check("R2 reads during handshake", rd_hv, 0);
        check("R2 power-up count", pu_rise, 1);
        compare_logs(0);
    endtask

    task automatic t_start_ignored;
        pulse(0);
        repeat (20) @(negedge clk);
        check("R9 start while on ignored", pu_rise, 1);
    endtask

    task automatic t_frame;
        for (int i = 1; i < 59; i++) begin
            int idx, pad;
            idx = i; pad = 0;
            if (i == 5)  idx = 63;
            if (i == 10) idx = 59;
            if (i == 20) pad = 1;
            push_entry(idx, pad, (i * 37 + 11) & 255);
            repeat (20) @(negedge clk);
            if (i == 57) check("R8 no frame_done before 59th", fd_n, 0);
        end
        repeat (20) @(negedge clk);
        check("R8 frame_done after 59th", fd_n, 1);
        check("R5 err_count", err_count, 2);
        check("R6 fmt_err sticky", fmt_err, 1);
        check("R7 read while empty", rd_bad, 0);
        compare_logs(1);
    endtask

    task automatic t_key_reset;
        pulse(2);
        check("R10 err_count cleared", err_count, 0);
        check("R10 fmt_err cleared", fmt_err, 0);
        check("R10 requests low", pu_req | smp_req | pd_req, 0);
        begin
            int rp0;
            rp0 = rp;
            push_entry(40, 0, 8'h3C);
            repeat (20) @(negedge clk);
            check("R10 powered off after key", rp - rp0, 0);
        end
    endtask

    task automatic t_shutdown_mid;
        int rp0, pd0;
        pulse(0);
        repeat (60) @(negedge clk);
        check("R2 second power-up", pu_rise, 2);
        pd0 = pd_rise;
        push_byte(8'((12 << 2) | 0));
        repeat (10) @(negedge clk);
        pulse(1);
        repeat (10) @(negedge clk);
        check("R9 shutdown waits for entry boundary", pd_rise, pd0);
        push_byte(8'h77);
        exp_v[exp_n] = 8'h77; exp_b[exp_n] = 0; exp_c[exp_n] = 12; exp_n++;
        repeat (40) @(negedge clk);
        check("R9 power-down raised", pd_rise, pd0 + 1);
        check("R9 power-down finished", pd_req, 0);
        compare_logs(59);
        rp0 = rp;
        push_entry(7, 0, 8'h11);
        exp_n--;
        repeat (20) @(negedge clk);
        check("R9 no reads after shutdown", rp - rp0, 0);
        check("R7 read while empty", rd_bad, 0);
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_start_ignored();
        t_frame();
        t_key_reset();
        t_shutdown_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule